// File: doc/BRIEF.md
# Write-Order Interlock for Unequal-Latency Pipeline

This block sits beside the decode stage of an in-order, single-issue pipeline in which integer operations retire on a short path while loads and stores run through a longer memory path. Each cycle it looks at the instruction in decode: its class, two source registers and one destination register. It then decides whether that instruction may leave decode this cycle or must wait. When it waits, execute receives a bubble.

Three orderings are protected. A consumer must not read a register before its producer's value exists; forwarding is assumed once a value is produced. A younger writer must not write back before an older in-flight write to the same register. A younger writer must not overwrite a register that an older store still has to read as store data. For each register the block keeps three small countdowns, measured in cycles: until the pending write, until the value becomes forwardable, and until the pending store-data read. These countdowns keep running while decode is stalled. A synchronous flush discards all pending state.

Timing is measured from the cycle an instruction leaves decode. From there an integer operation writes back 2 cycles later, and its value can be forwarded to the next instruction. A load writes back 4 cycles later, and its value can feed an instruction that leaves decode 3 cycles after it. A store reads its data register 4 cycles later.

Top module: `wo_interlock`

## Requirements
- R1: Out of reset no register has pending state, so any instruction presented first leaves decode without a stall.
- R2: An instruction whose sources and destination hit no pending countdown is never stalled. This includes an integer operation that consumes the result of the integer operation directly ahead of it.
- R3: An instruction reading a load's destination (through rs1 for any class, or through rs2 for integer and store) stalls for exactly 2 cycles when it directly follows the load, and then leaves decode.
- R4: An integer operation writing the destination of a load issued the cycle before stalls 2 cycles, so that its write-back comes strictly after the load's.
- R5: An integer operation writing the data register (rs2) of a store issued the cycle before stalls 2 cycles, so that its write comes strictly after the store's late data read.
- R6: A load that writes a store's data register, or the destination of a preceding load, right after that instruction is not stalled, because its own write already lands later.
- R7: Register 0 never causes a stall, whether it is used as a source or as a destination.
- R8: While `flush` is high, `stall` and `ex_take` are low. All pending state is cleared, so an instruction that would have waited on the flushed producer goes through on the next cycle.
- R9: Class encoding on `dec_cls` is 00 none, 01 integer (reads rs1 and rs2, writes rd), 10 load (reads rs1, writes rd), 11 store (reads rs1 and rs2, with rs2 as the late-read data, writes nothing). `ex_take` is high exactly when the class is not none, `stall` is low and `flush` is low.
- R10: For any mix of instructions held in decode while stalled, `stall` matches a schedule built from the per-instruction write, ready and store-read cycles given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all pending state |
| dec_cls | input | 2 | Class of the decode instruction |
| dec_rs1 | input | RW | First source register |
| dec_rs2 | input | RW | Second source register (store data for stores) |
| dec_rd | input | RW | Destination register |
| stall | output | 1 | Hold decode and send a bubble into execute |
| ex_take | output | 1 | Decode instruction moves into execute this cycle |

## Verification
Directed pairs place each producer class directly ahead of each consumer class on a shared register. This separates the two-cycle load-use wait, the write-after-write wait and the late store-read wait from the pairs that must flow freely: integer to integer, load after store on the data register, and load after load. Register-0 and flush patterns show that pending state is ignored or discarded rather than merely delayed. A long random mix over only four registers produces overlapping hazards with the held instruction re-presented every stalled cycle, and each cycle is compared against a schedule computed from absolute issue times instead of countdowns.

// File: rtl/wo_interlock.sv
module wo_interlock #(
  parameter int NREG   = 32,
  parameter int INT_WB = 2,
  parameter int LD_WB  = 4,
  parameter int LD_USE = 3,
  parameter int ST_RD  = 4,
  localparam int RW    = $clog2(NREG),
  localparam int MAXL  = (LD_WB > ST_RD) ? ((LD_WB > INT_WB) ? LD_WB : INT_WB)
                                         : ((ST_RD > INT_WB) ? ST_RD : INT_WB),
  localparam int CW    = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    dec_cls,
  input  logic [RW-1:0] dec_rs1,
  input  logic [RW-1:0] dec_rs2,
  input  logic [RW-1:0] dec_rd,
  output logic          stall,
  output logic          ex_take
);

  localparam logic [1:0] C_NONE = 2'd0, C_INT = 2'd1, C_LD = 2'd2, C_ST = 2'd3;

  logic [CW-1:0] wr_cnt [NREG];
  logic [CW-1:0] rdy_cnt [NREG];
  logic [CW-1:0] srd_cnt [NREG];

  wire is_ld   = dec_cls == C_LD;
  wire writes  = (dec_cls == C_INT || is_ld) && dec_rd != '0;
  wire use1    = dec_cls != C_NONE && dec_rs1 != '0;
  wire use2    = (dec_cls == C_INT || dec_cls == C_ST) && dec_rs2 != '0;
  wire st_data = dec_cls == C_ST && dec_rs2 != '0;

  wire [CW-1:0] lat_new = is_ld ? CW'(LD_WB) : CW'(INT_WB);

  wire raw1 = use1 && rdy_cnt[dec_rs1] != '0;
  wire raw2 = use2 && rdy_cnt[dec_rs2] != '0;
  wire waw  = writes && wr_cnt[dec_rd] >= lat_new;
  wire war  = writes && srd_cnt[dec_rd] >= lat_new;

  assign stall   = !flush && (raw1 || raw2 || waw || war);
  assign ex_take = !flush && !stall && dec_cls != C_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        wr_cnt[i]  <= '0;
        rdy_cnt[i] <= '0;
        srd_cnt[i] <= '0;
      end
    end else if (flush) begin
      for (int i = 0; i < NREG; i++) begin
        wr_cnt[i]  <= '0;
        rdy_cnt[i] <= '0;
        srd_cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ex_take && writes && dec_rd == RW'(i)) begin
          wr_cnt[i]  <= lat_new - 1'b1;
          rdy_cnt[i] <= is_ld ? CW'(LD_USE - 1) : '0;
        end else begin
          if (wr_cnt[i] != '0)  wr_cnt[i]  <= wr_cnt[i] - 1'b1;
          if (rdy_cnt[i] != '0) rdy_cnt[i] <= rdy_cnt[i] - 1'b1;
        end
        if (ex_take && st_data && dec_rs2 == RW'(i))
          srd_cnt[i] <= CW'(ST_RD - 1);
        else if (srd_cnt[i] != '0)
          srd_cnt[i] <= srd_cnt[i] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/wo_interlock_chk.sv
module wo_interlock_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [1:0]    dec_cls,
  input logic [RW-1:0] dec_rs1,
  input logic [RW-1:0] dec_rs2,
  input logic [RW-1:0] dec_rd,
  input logic          stall,
  input logic          ex_take
);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !stall);

  a_r7_zero_regs_free: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cls != 2'd0 && dec_rs1 == '0 && dec_rs2 == '0 && dec_rd == '0) |-> !stall);

  a_r3_load_use_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_take && dec_cls == 2'd2 && dec_rd != '0) |=>
      (!(dec_cls != 2'd0 && dec_rs1 == $past(dec_rd) && !flush) || stall));

  a_r5_store_read_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_take && dec_cls == 2'd3 && dec_rs2 != '0) |=>
      (!(dec_cls == 2'd1 && dec_rd == $past(dec_rs2) && !flush) || stall));

  a_r9_take_excludes_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ex_take |-> (dec_cls != 2'd0 && !stall && !flush));

endmodule

bind wo_interlock wo_interlock_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .dec_cls(dec_cls),
  .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd),
  .stall(stall), .ex_take(ex_take)
);

// File: tb/wo_interlock_test.sv
module wo_interlock_test;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [1:0] dec_cls = 2'd0;
  logic [4:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
  logic stall, ex_take;

  always #2.5 clk = ~clk;

  wo_interlock uut (.clk(clk), .rst_n(rst_n), .flush(flush), .dec_cls(dec_cls),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd),
    .stall(stall), .ex_take(ex_take));

  int n_run = 0, n_fail = 0, cyc = 1;
  bit done = 0;
  int wr_t [32], av_t [32], sr_t [32];

  // {flush, cls, rs1, rs2, rd, expected stall}
  localparam int NV = 23;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd1, 5'd2,  5'd3,  5'd1,  1'b0},  // R2
    {1'b0, 2'd1, 5'd1,  5'd1,  5'd4,  1'b0},  // R2 int->int forward
    {1'b0, 2'd2, 5'd2,  5'd0,  5'd5,  1'b0},
    {1'b0, 2'd1, 5'd5,  5'd0,  5'd6,  1'b1},  // R3
    {1'b0, 2'd1, 5'd5,  5'd0,  5'd6,  1'b1},  // R3
    {1'b0, 2'd1, 5'd5,  5'd0,  5'd6,  1'b0},  // R3
    {1'b0, 2'd2, 5'd0,  5'd0,  5'd7,  1'b0},
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd7,  1'b1},  // R4
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd7,  1'b1},  // R4
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd7,  1'b0},  // R4
    {1'b0, 2'd3, 5'd0,  5'd8,  5'd0,  1'b0},
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd8,  1'b1},  // R5
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd8,  1'b1},  // R5
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd8,  1'b0},  // R5
    {1'b0, 2'd3, 5'd0,  5'd9,  5'd0,  1'b0},
    {1'b0, 2'd2, 5'd0,  5'd0,  5'd9,  1'b0},  // R6
    {1'b0, 2'd2, 5'd0,  5'd0,  5'd10, 1'b0},
    {1'b0, 2'd2, 5'd0,  5'd0,  5'd10, 1'b0},  // R6
    {1'b0, 2'd2, 5'd0,  5'd0,  5'd0,  1'b0},
    {1'b0, 2'd1, 5'd0,  5'd0,  5'd0,  1'b0},  // R7
    {1'b0, 2'd2, 5'd0,  5'd0,  5'd11, 1'b0},
    {1'b1, 2'd1, 5'd11, 5'd0,  5'd12, 1'b0},  // R8
    {1'b0, 2'd1, 5'd11, 5'd0,  5'd12, 1'b0}   // R8
  };

  function automatic bit model_stall(bit fl, logic [1:0] c, int s1, int s2, int d);
    int lat;
    bit h;
    if (fl || c == 2'd0) return 0;
    lat = (c == 2'd2) ? 4 : 2;
    h = 0;
    if (s1 != 0 && av_t[s1] > cyc) h = 1;
    if ((c == 2'd1 || c == 2'd3) && s2 != 0 && av_t[s2] > cyc) h = 1;
    if ((c == 2'd1 || c == 2'd2) && d != 0 &&
        (wr_t[d] >= cyc + lat || sr_t[d] >= cyc + lat)) h = 1;
    return h;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 32; i++) begin
      wr_t[i] = 0; av_t[i] = 0; sr_t[i] = 0;
    end
  endtask

  task automatic step(bit fl, logic [1:0] c, int s1, int s2, int d, int want, string tag);
    bit exp_st, exp_tk;
    @(negedge clk);
    flush = fl; dec_cls = c;
    dec_rs1 = 5'(s1); dec_rs2 = 5'(s2); dec_rd = 5'(d);
    #1;
    exp_st = (want < 0) ? model_stall(fl, c, s1, s2, d) : bit'(want);
    exp_tk = !fl && !exp_st && c != 2'd0;
    n_run++;
    if (stall !== exp_st) begin
      n_fail++;
      $display("FAIL %s cyc=%0d stall actual=%b expected=%b", tag, cyc, stall, exp_st);
    end
    n_run++;
    if (ex_take !== exp_tk) begin
      n_fail++;
      $display("FAIL R9 cyc=%0d ex_take actual=%b expected=%b", cyc, ex_take, exp_tk);
    end
    if (fl) clear_model();
    else if (exp_tk) begin
      if ((c == 2'd1 || c == 2'd2) && d != 0) begin
        wr_t[d] = cyc + ((c == 2'd2) ? 4 : 2);
        av_t[d] = cyc + ((c == 2'd2) ? 3 : 1);
      end
      if (c == 2'd3 && s2 != 0) sr_t[s2] = cyc + 4;
    end
    cyc++;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] c;
    int s1, s2, d;
    bit fl;
    clear_model();
    repeat (3) @(negedge clk);
    n_run++;
    if (stall !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 stall in reset actual=%b expected=0", stall);
    end
    rst_n = 1'b1;
    // R1: a hazard-shaped first instruction must not stall
    step(0, 2'd1, 7, 9, 3, 0, "R1");
    for (int k = 0; k < NV; k++)
      step(VEC[k][18], VEC[k][17:16], int'(VEC[k][15:11]), int'(VEC[k][10:6]),
           int'(VEC[k][5:1]), int'(VEC[k][0]), "R2-R8 table");
    // R7: register 0 as store data then written
    step(0, 2'd3, 0, 0, 0, 0, "R7");
    step(0, 2'd1, 0, 0, 0, 0, "R7");
    // R3: rs2 use of a load result by a store
    step(0, 2'd2, 0, 0, 13, 0, "R3");
    step(0, 2'd3, 0, 13, 0, 1, "R3");
    step(0, 2'd3, 0, 13, 0, 1, "R3");
    step(0, 2'd3, 0, 13, 0, 0, "R3");
    // R10: random mix, held while stalled
    step(1, 2'd0, 0, 0, 0, 0, "R8");
    c = 2'd0; s1 = 0; s2 = 0; d = 0; fl = 0;
    for (int k = 0; k < 3000; k++) begin
      if (!model_stall(0, c, s1, s2, d) || fl) begin
        c = 2'($urandom % 4);
        s1 = $urandom % 4; s2 = $urandom % 4; d = $urandom % 4;
      end
      fl = ($urandom % 40) == 0;
      step(fl, c, s1, s2, d, -1, "R10");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule